// File: doc/BRIEF.md
# Branch Trace Address Compressor

This block sits beside a CPU core and turns each taken branch into a short packet on a 4-bit trace port. The CPU presents a branch with its source and destination addresses. The block queues the event in a four-entry queue and later sends it out one nibble per cycle. The source address is shortened against the source address of the last packet that actually left the block. Only the low 4, 8, 16 or 32 bits are sent, chosen by how many upper bits still agree. The destination address is always sent in full. A receiver that starts from a zero reference after reset can rebuild every source address from the packets alone.

The mode input selects how a full queue is handled. In realtime mode the CPU is never held back: a branch that finds the queue full is discarded, and a saturating counter records the loss. In stalling mode the block raises a stall request whenever a branch arrives while earlier trace data is still waiting or being sent. The request stays up until every queued packet has left the port, so a CPU that honours it loses nothing. Some branches are marked as not to be traced, namely conditional branches with a zero displacement and the jump taken at reset. These have no effect at all.

Top module: `brtrace_packer`

## Requirements
- R1: After reset, tp_sync, tp_data, cpu_stall and drop_count are all zero. The source reference used for compression is zero, so the first packet is compressed against address 0.
- R2: A packet begins with one cycle in which tp_sync is 1, tp_data[1:0] carries the length code and tp_data[3:2] is 0. It continues with the kept source nibbles, least significant first, and then the 8 destination nibbles, least significant first. tp_sync is 0 on every cycle of a packet except its first.
- R3: The length code is chosen in priority order. Code 0 (4 bits sent) applies when source bits 31:4 equal the reference. Otherwise code 1 (8 bits) applies when bits 31:8 match. Otherwise code 2 (16 bits) applies when bits 31:16 match. Otherwise code 3 (all 32 bits) applies.
- R4: The reference takes the full source address of each packet that is sent. Dropped and untraced branches never change it.
- R5: Queued branches leave the port in arrival order. The block holds four waiting events plus the one being sent. A burst of back-to-back branches that reaches an idle block in realtime mode keeps the first five branches and discards the rest.
- R6: In realtime mode, a traced branch that finds the queue full is discarded and drop_count rises by one. cpu_stall is 0 on every cycle that follows a cycle with realtime mode selected.
- R7: In stalling mode, a traced branch that arrives while a packet is being sent or the queue is not empty raises cpu_stall from the next cycle. cpu_stall stays high until the last nibble of every pending packet has been sent. A CPU that honours cpu_stall never causes a drop.
- R8: In stalling mode, a traced branch that reaches a fully idle block does not raise cpu_stall.
- R9: A branch presented with br_skip high produces no packet, does not change drop_count and does not raise cpu_stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rt_mode | input | 1 | 1: realtime (drop on full queue), 0: stall the CPU |
| br_valid | input | 1 | A branch is presented this cycle |
| br_skip | input | 1 | The presented branch must not be traced |
| br_src | input | 32 | Branch source address |
| br_dst | input | 32 | Branch destination address |
| tp_data | output | 4 | Trace port nibble |
| tp_sync | output | 1 | High on the first cycle of each packet |
| cpu_stall | output | 1 | Request that the CPU hold its next branch |
| drop_count | output | DROP_W | Saturating count of branches discarded on a full queue |

## Verification
The hardest state to reach from the ports is a full queue that still holds the compression reference from the last sent packet while newer branches are discarded. Reaching it needs a burst that outruns a packet already in flight. The bench drives ten branches on consecutive cycles into an idle block in realtime mode and gives the discarded ones addresses far from the kept ones. The branch that follows must still compress against the last kept address, so any reference update from a dropped branch changes its length code. Random bursts with short gaps, and a stalling-mode phase in which the bench waits on cpu_stall, cover the remaining mix of lengths.

// File: rtl/brt_pkg.sv
package brt_pkg;
  localparam int ADDR_W = 32;
  localparam int NIB_W  = 4;
  localparam int DST_NIBS = ADDR_W / NIB_W;

  typedef logic [1:0] len_code_t;
  localparam len_code_t LEN_4  = 2'd0;
  localparam len_code_t LEN_8  = 2'd1;
  localparam len_code_t LEN_16 = 2'd2;
  localparam len_code_t LEN_32 = 2'd3;

  typedef struct packed {
    logic [ADDR_W-1:0] dst;
    logic [ADDR_W-1:0] src;
  } brt_evt_t;

  typedef enum logic [1:0] {S_IDLE, S_LOAD, S_SEND} ser_state_t;

  // number of source nibbles carried for a length code
  function automatic logic [4:0] src_nibbles(len_code_t c);
    return 5'd1 << c;
  endfunction
endpackage

// File: rtl/brt_fifo.sv
module brt_fifo #(
  parameter int W     = 64,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] rdata,
  output logic         empty,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;

  assign empty = (count == '0);
  assign full  = (count == CW'(DEPTH));

  function automatic logic [AW-1:0] bump(logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  // storage without reset and registered read: maps onto block RAM
  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= wdata;
    if (pop)  rdata <= mem[rd_ptr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      case ({push, pop})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end

  p_no_push_full_r5: assert property (@(posedge clk) disable iff (rst)
    full |-> !push);
  p_no_pop_empty_r5: assert property (@(posedge clk) disable iff (rst)
    empty |-> !pop);
  p_count_bound_r5: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH));
endmodule

// File: rtl/brt_len_enc.sv
module brt_len_enc
  import brt_pkg::*;
(
  input  logic [ADDR_W-1:0] src,
  input  logic [ADDR_W-1:0] last_src,
  output len_code_t         code
);
  // longest upper match wins: 28 bits, then 24, then 16
  always_comb begin
    if (src[ADDR_W-1:4] == last_src[ADDR_W-1:4])       code = LEN_4;
    else if (src[ADDR_W-1:8] == last_src[ADDR_W-1:8])  code = LEN_8;
    else if (src[ADDR_W-1:16] == last_src[ADDR_W-1:16]) code = LEN_16;
    else                                               code = LEN_32;
  end
endmodule

// File: rtl/brt_serial.sv
module brt_serial
  import brt_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             q_empty,
  input  brt_evt_t         q_data,
  output logic             q_pop,
  output logic             busy,
  output logic [NIB_W-1:0] tp_data,
  output logic             tp_sync
);
  localparam int SH_W = 2 * ADDR_W;

  ser_state_t        state;
  logic [ADDR_W-1:0] last_src;
  logic [SH_W-1:0]   sh, sh_load;
  logic [4:0]        rem;
  len_code_t         code;

  brt_len_enc u_enc (.src(q_data.src), .last_src(last_src), .code(code));

  // kept source bits in the low nibbles, destination right above them
  always_comb begin
    case (code)
      LEN_4:   sh_load = {28'b0, q_data.dst, q_data.src[3:0]};
      LEN_8:   sh_load = {24'b0, q_data.dst, q_data.src[7:0]};
      LEN_16:  sh_load = {16'b0, q_data.dst, q_data.src[15:0]};
      default: sh_load = {q_data.dst, q_data.src};
    endcase
  end

  assign q_pop = (state == S_IDLE) && !q_empty;
  assign busy  = (state != S_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= S_IDLE;
      last_src <= '0;
      sh       <= '0;
      rem      <= '0;
      tp_data  <= '0;
      tp_sync  <= 1'b0;
    end else begin
      case (state)
        S_IDLE: begin
          tp_sync <= 1'b0;
          tp_data <= '0;
          if (!q_empty) state <= S_LOAD;
        end
        S_LOAD: begin
          tp_sync  <= 1'b1;
          tp_data  <= {2'b00, code};
          last_src <= q_data.src;
          sh       <= sh_load;
          rem      <= src_nibbles(code) + 5'(DST_NIBS);
          state    <= S_SEND;
        end
        default: begin
          tp_sync <= 1'b0;
          tp_data <= sh[NIB_W-1:0];
          sh      <= sh >> NIB_W;
          rem     <= rem - 5'd1;
          if (rem == 5'd1) state <= S_IDLE;
        end
      endcase
    end
  end

  p_sync_single_r2: assert property (@(posedge clk) disable iff (rst)
    tp_sync |=> !tp_sync);
  p_sync_hi_zero_r2: assert property (@(posedge clk) disable iff (rst)
    tp_sync |-> (tp_data[3:2] == 2'b00));
  p_ref_from_sent_r4: assert property (@(posedge clk) disable iff (rst)
    !$past(q_pop) && (state != S_SEND) && $past(state != S_LOAD) |-> $stable(last_src));
endmodule

// File: rtl/brtrace_packer.sv
module brtrace_packer
  import brt_pkg::*;
#(
  parameter int DEPTH  = 4,
  parameter int DROP_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rt_mode,
  input  logic              br_valid,
  input  logic              br_skip,
  input  logic [31:0]       br_src,
  input  logic [31:0]       br_dst,
  output logic [3:0]        tp_data,
  output logic              tp_sync,
  output logic              cpu_stall,
  output logic [DROP_W-1:0] drop_count
);
  localparam int EVT_W = $bits(brt_evt_t);

  logic     evt_ok, q_push, q_pop, q_empty, q_full, ser_busy, pending;
  brt_evt_t wr_evt, rd_evt;
  logic [EVT_W-1:0] rd_raw;
  logic     stall_q;
  logic [DROP_W-1:0] drop_q;

  assign evt_ok = br_valid && !br_skip;
  assign q_push = evt_ok && !q_full;
  assign wr_evt = '{dst: br_dst, src: br_src};
  assign rd_evt = brt_evt_t'(rd_raw);
  assign pending = ser_busy || !q_empty;

  brt_fifo #(.W(EVT_W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .push(q_push), .wdata(wr_evt),
    .pop(q_pop), .rdata(rd_raw), .empty(q_empty), .full(q_full)
  );

  brt_serial u_ser (
    .clk(clk), .rst(rst), .q_empty(q_empty), .q_data(rd_evt),
    .q_pop(q_pop), .busy(ser_busy), .tp_data(tp_data), .tp_sync(tp_sync)
  );

  // stall request: raised by a branch arriving on pending work, held to drain
  always_ff @(posedge clk) begin
    if (rst || rt_mode) stall_q <= 1'b0;
    else if (stall_q)   stall_q <= pending;
    else                stall_q <= evt_ok && pending;
  end

  always_ff @(posedge clk) begin
    if (rst) drop_q <= '0;
    else if (evt_ok && q_full && (drop_q != '1)) drop_q <= drop_q + DROP_W'(1);
  end

  assign cpu_stall  = stall_q;
  assign drop_count = drop_q;

  p_rt_no_stall_r6: assert property (@(posedge clk) disable iff (rst)
    rt_mode |=> !cpu_stall);
  p_drop_inc_r6: assert property (@(posedge clk) disable iff (rst)
    (evt_ok && q_full && (drop_count != '1)) |=> (drop_count == $past(drop_count) + DROP_W'(1)));
  p_skip_inert_r9: assert property (@(posedge clk) disable iff (rst)
    (br_valid && br_skip) |=> (drop_count == $past(drop_count)));
  p_stall_on_pending_r7: assert property (@(posedge clk) disable iff (rst)
    (!rt_mode && evt_ok && pending) |=> cpu_stall);
  p_idle_no_stall_r8: assert property (@(posedge clk) disable iff (rst)
    (!cpu_stall && !pending) |=> !cpu_stall);
endmodule

// File: tb/test_brtrace_packer.sv
module test_brtrace_packer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rt_mode = 1'b0, br_valid = 1'b0, br_skip = 1'b0;
  logic [31:0] br_src = '0, br_dst = '0;
  logic [3:0]  tp_data;
  logic        tp_sync, cpu_stall;
  logic [15:0] drop_count;

  always #10 clk = ~clk;

  brtrace_packer i_brtrace_packer (
    .clk(clk), .rst(rst), .rt_mode(rt_mode), .br_valid(br_valid),
    .br_skip(br_skip), .br_src(br_src), .br_dst(br_dst), .tp_data(tp_data),
    .tp_sync(tp_sync), .cpu_stall(cpu_stall), .drop_count(drop_count)
  );

  int nchk = 0, nfail = 0, pkts = 0, rt_stall_seen = 0;
  int seen [4] = '{0, 0, 0, 0};
  logic [31:0] exp_src [$];
  logic [31:0] exp_dst [$];
  logic [31:0] bref = '0;
  int need = 0, got = 0;
  logic [1:0]  mcode = '0;
  logic [63:0] acc = '0;

  task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [1:0] model_code(logic [31:0] s, logic [31:0] r);
    if (s[31:4] == r[31:4]) return 2'd0;
    if (s[31:8] == r[31:8]) return 2'd1;
    if (s[31:16] == r[31:16]) return 2'd2;
    return 2'd3;
  endfunction

  task automatic finish_packet();
    logic [31:0] s, d;
    logic [1:0]  ec;
    int          n;
    logic [63:0] mask;
    if (exp_src.size() == 0) begin
      chk(1'b0, "R5 unexpected packet", acc, 64'd0);
      return;
    end
    s = exp_src.pop_front();
    d = exp_dst.pop_front();
    ec = model_code(s, bref);
    n = 1 << ec;
    mask = (64'd1 << (4 * n)) - 64'd1;
    chk(mcode == ec, "R3 length code", {62'd0, mcode}, {62'd0, ec});
    chk((acc & mask) == ({32'd0, s} & mask), "R4 compressed source", acc & mask, {32'd0, s} & mask);
    chk((acc >> (4 * n)) == {32'd0, d}, "R2 destination", acc >> (4 * n), {32'd0, d});
    seen[ec]++;
    bref = s;
    pkts++;
  endtask

  // packet decoder on the trace port
  always @(negedge clk) begin
    if (!rst) begin
      if (rt_mode && cpu_stall) rt_stall_seen++;
      if (need == 0) begin
        if (tp_sync) begin
          chk(tp_data[3:2] == 2'b00, "R2 sync upper bits", {60'd0, tp_data}, {62'd0, tp_data[1:0]});
          mcode = tp_data[1:0];
          need = (1 << tp_data[1:0]) + 8;
          got = 0;
          acc = '0;
        end
      end else begin
        if (tp_sync) chk(1'b0, "R2 sync inside packet", 64'd1, 64'd0);
        acc = acc | ({60'd0, tp_data} << (4 * got));
        got++;
        need--;
        if (need == 0) finish_packet();
      end
    end
  end

  // present one branch; returns at the next falling edge
  task automatic ev(input logic [31:0] s, input logic [31:0] d, input logic sk);
    logic [15:0] dc0;
    dc0 = drop_count;
    br_valid = 1'b1; br_src = s; br_dst = d; br_skip = sk;
    @(negedge clk);
    br_valid = 1'b0; br_skip = 1'b0;
    if (sk) chk(drop_count == dc0, "R9 skipped branch drop count", {48'd0, drop_count}, {48'd0, dc0});
    else if (drop_count == dc0) begin
      exp_src.push_back(s);
      exp_dst.push_back(d);
    end
  endtask

  task automatic ev_held(input logic [31:0] s, input logic [31:0] d, input logic sk);
    while (cpu_stall) @(negedge clk);
    ev(s, d, sk);
  endtask

  task automatic drain();
    int t = 0;
    while ((exp_src.size() != 0 || need != 0 || cpu_stall) && t < 4000) begin
      @(negedge clk);
      t++;
    end
    repeat (3) @(negedge clk);
  endtask

  function automatic logic [31:0] next_addr(logic [31:0] p);
    case ($urandom_range(0, 3))
      0: return p ^ ($urandom & 32'h0000_000F);
      1: return p ^ ($urandom & 32'h0000_00FF);
      2: return p ^ ($urandom & 32'h0000_FFFF);
      default: return $urandom;
    endcase
  endfunction

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired R5 actual 0 expected 1");
    summary();
    $finish;
  end

  initial begin
    logic [15:0] dc0;
    logic [31:0] a;
    int p0;
    void'($urandom(32'h0BAD_5EED));
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(tp_sync == 1'b0, "R1 tp_sync after reset", {63'd0, tp_sync}, 64'd0);
    chk(tp_data == 4'd0, "R1 tp_data after reset", {60'd0, tp_data}, 64'd0);
    chk(cpu_stall == 1'b0, "R1 cpu_stall after reset", {63'd0, cpu_stall}, 64'd0);
    chk(drop_count == 16'd0, "R1 drop_count after reset", {48'd0, drop_count}, 64'd0);

    // R8 then R7, stalling mode; first packet compares against zero (R1)
    rt_mode = 1'b0;
    ev(32'h0000_0009, 32'h8000_0000, 1'b0);
    chk(cpu_stall == 1'b0, "R8 no stall on idle arrival", {63'd0, cpu_stall}, 64'd0);
    ev(32'h1234_5678, 32'h1111_2222, 1'b0);
    chk(cpu_stall == 1'b1, "R7 stall on pending arrival", {63'd0, cpu_stall}, 64'd1);
    while (cpu_stall) @(negedge clk);
    chk(pkts == 2 && need == 0, "R7 stall held until drained", pkts, 64'd2);

    // R3 priority of length codes
    ev_held(32'h1234_567F, 32'hA000_0001, 1'b0);
    ev_held(32'h1234_56A0, 32'hA000_0002, 1'b0);
    ev_held(32'h1234_9999, 32'hA000_0003, 1'b0);
    ev_held(32'hFFFF_0000, 32'hA000_0004, 1'b0);
    ev_held(32'hFFFF_0003, 32'hA000_0005, 1'b0);
    drain();

    // R5 burst into an idle block, realtime; dropped ones far away (R4)
    rt_mode = 1'b1;
    dc0 = drop_count;
    p0 = pkts;
    for (int i = 0; i < 10; i++)
      ev((i < 5) ? 32'hAAAA_0000 + i : 32'h5555_5555, 32'hB000_0000 + i, 1'b0);
    chk(drop_count - dc0 == 16'd5, "R5 burst drops", {48'd0, drop_count - dc0}, 64'd5);
    chk(drop_count - dc0 == 16'd5, "R6 drop counter in realtime", {48'd0, drop_count}, {48'd0, dc0 + 16'd5});
    ev(32'h7777_7777, 32'h0, 1'b1);
    ev(32'h7777_7777, 32'h0, 1'b1);
    drain();
    chk(pkts - p0 == 5, "R5 burst packets kept", pkts - p0, 64'd5);
    // must compress against 0xAAAA_0004, not a dropped address (R4)
    p0 = seen[1];
    ev(32'hAAAA_0010, 32'hC000_0000, 1'b0);
    drain();
    chk(seen[1] == p0 + 1, "R4 reference ignores drops", seen[1], p0 + 1);

    // R9 skipped branch into an idle block
    p0 = pkts;
    ev(32'h0BAD_0000, 32'h0BAD_0001, 1'b1);
    repeat (30) @(negedge clk);
    chk(pkts == p0, "R9 skipped branch sends nothing", pkts, p0);
    chk(cpu_stall == 1'b0, "R9 skipped branch no stall", {63'd0, cpu_stall}, 64'd0);

    // random realtime traffic
    a = $urandom;
    for (int i = 0; i < 300; i++) begin
      a = next_addr(a);
      ev(a, $urandom, ($urandom_range(0, 7) == 0));
      if ($urandom_range(0, 9) == 0) repeat ($urandom_range(5, 30)) @(negedge clk);
    end
    drain();

    // random stalling traffic: CPU honours the stall
    rt_mode = 1'b0;
    dc0 = drop_count;
    for (int i = 0; i < 300; i++) begin
      a = next_addr(a);
      ev_held(a, $urandom, ($urandom_range(0, 7) == 0));
      if ($urandom_range(0, 3) == 0) repeat ($urandom_range(1, 20)) @(negedge clk);
    end
    drain();
    chk(drop_count == dc0, "R7 no drops when stall honoured", {48'd0, drop_count}, {48'd0, dc0});

    chk(exp_src.size() == 0, "R5 every kept branch delivered", exp_src.size(), 64'd0);
    for (int k = 0; k < 4; k++)
      chk(seen[k] > 0, "R3 each length code used", seen[k], 64'd1);
    chk(rt_stall_seen == 0, "R6 no stall in realtime", rt_stall_seen, 64'd0);
    summary();
    $finish;
  end
endmodule